// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire serial bus with open-drain clock and data lines. It holds a small byte array in registers and lets a bus controller write and read it. The serial lines are oversampled by the system clock. Start and Stop conditions, clock edges and data bits are all recovered from the synchronized samples. The block never drives the data line high. It only enables a low-side driver through `sda_oe`.

A transaction opens with a Start and a device byte. The upper seven bits of that byte are the target's identity and the lowest bit selects the direction. A write carries three address bytes, most significant first, and then data bytes. An internal address counter selects the byte that a read returns and the byte that a write stores. Loading the address and then stopping without data sets the counter for a later read. A read that follows this is a random read. A read that follows nothing else is a current address read. A read in which the controller acknowledges each byte is a sequential read.

The counter keeps its value between transactions as long as the active-low serial enable stays low. Raising the enable, or applying reset, clears the counter to zero.

Top module: `twm_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and the address counter is 0. A current address read as the first transaction therefore returns byte 0.
- R2: A device byte whose bits [7:1], sent MSB first, equal `DEV_ID` (default 7'h50) is acknowledged: `sda_oe` is 1 during the ninth clock. Bit 0 = 1 selects a read and bit 0 = 0 selects a write.
- R3: A device byte with any other identity is not acknowledged. Every later byte up to the next Start is also left unacknowledged and stores nothing.
- R4: A write carries three address bytes, most significant first, and each is acknowledged. Only the low log2(MEM_DEPTH) bits of the 24-bit value are used; the upper bits have no effect.
- R5: Each write data byte is acknowledged and stored at the counter, and the counter then advances by one. From the last byte of a page (offset PAGE_BYTES-1) it moves to offset 0 of the next page. From the last byte of the array it moves to 0.
- R6: A current address read sends the byte at the counter, MSB first, and then advances the counter by one.
- R7: A write that stops after its third address byte loads the counter. A following Start and read device byte then return the byte at the loaded address.
- R8: When the controller acknowledges a read byte, the next byte is sent. When it does not acknowledge, the target releases SDA and sends nothing more until the next Start.
- R9: The counter keeps its value across Stop, Start and unaddressed transactions while `ser_en_n` is low. Driving `ser_en_n` high clears it to 0 and releases SDA.
- R10: Start is SDA falling while SCL is high and Stop is SDA rising while SCL is high. The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Active-low serial enable; high clears the counter |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A wrong internal state first shows on `sda_oe`. A wrong identity decode or a wrong byte count moves or removes the acknowledge in the ninth clock of the byte. A counter that steps wrongly, fails to persist or fails to clear returns the wrong byte on the very next read, and that byte is visible bit by bit within eight SCL periods. The bench reads every stored value back over the bus. It also watches `sda_oe` against SCL for the whole run, so a drive change during a high clock phase is caught at the edge where it happens.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } twm_state_e;

  // Address that follows cur: the end of a page steps into the next page,
  // and the end of the array wraps to zero.
  function automatic int unsigned next_addr(int unsigned cur, int unsigned page,
                                            int unsigned depth);
    int unsigned off;
    int unsigned nxt;
    off = cur % page;
    if (off == page - 1) nxt = (cur - off) + page;
    else                 nxt = cur + 1;
    if (nxt >= depth) nxt = 0;
    return nxt;
  endfunction

endpackage

// File: rtl/twm_bus_sync.sv
module twm_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s    = scl_p[STAGES-1];
  assign sda_s    = sda_p[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twm_addr_ctr.sv
module twm_addr_ctr #(
  parameter int unsigned MEM_DEPTH  = 256,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ctr
);
  logic [AW-1:0] ctr_next;
  assign ctr_next = AW'(twm_pkg::next_addr(32'(ctr), PAGE_BYTES, MEM_DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctr <= '0;
    else if (clr)  ctr <= '0;
    else if (load) ctr <= load_val;
    else if (step) ctr <= ctr_next;
  end

  // R9: a raised enable leaves the counter at zero
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctr == '0));

  // R5 / R6: a finished data byte moves the counter to the following address
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load) |=> (32'(ctr) ==
      twm_pkg::next_addr(32'($past(ctr)), PAGE_BYTES, MEM_DEPTH)));
endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int unsigned MEM_DEPTH = 256,
  localparam int unsigned AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] arr [MEM_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(MEM_DEPTH); i++) arr[i] <= '0;
    end else if (we) begin
      arr[waddr] <= wdata;
    end
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/twm_target.sv
module twm_target #(
  parameter logic [6:0]  DEV_ID      = 7'h50,
  parameter int unsigned MEM_DEPTH   = 256,
  parameter int unsigned PAGE_BYTES  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import twm_pkg::*;

  localparam int unsigned AW        = $clog2(MEM_DEPTH);
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned CW        = $clog2(BYTE_BITS + 1);
  localparam int unsigned ADDR_BYTES = 3;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_ev, .stop_ev
  );

  twm_state_e    state, after_ack;
  logic [CW-1:0] bitcnt;
  logic [7:0]    shreg;
  logic [1:0]    abyte;
  logic [AW-1:0] addr_acc;
  logic [AW-1:0] ctr;
  logic [7:0]    rd_byte;

  // Named internal events, shared by the datapath and the assertions
  logic live, byte_end, dev_hit, dev_miss, addr_last, wr_commit, rd_done, nack_seen;
  assign live      = !ser_en_n && !start_ev && !stop_ev;
  assign byte_end  = live && scl_fall && (bitcnt == CW'(BYTE_BITS));
  assign dev_hit   = byte_end && (state == ST_DEV) && (shreg[7:1] == DEV_ID);
  assign dev_miss  = byte_end && (state == ST_DEV) && (shreg[7:1] != DEV_ID);
  assign addr_last = byte_end && (state == ST_ADDR) && (abyte == 2'(ADDR_BYTES - 1));
  assign wr_commit = byte_end && (state == ST_WDATA);
  assign rd_done   = byte_end && (state == ST_RDATA);
  assign nack_seen = live && (state == ST_RACK) && scl_rise && sda_s;

  twm_addr_ctr #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_ctr (
    .clk, .rst_n,
    .clr      (ser_en_n),
    .load     (addr_last),
    .load_val (AW'({addr_acc, shreg})),
    .step     (wr_commit || rd_done),
    .ctr
  );

  twm_mem #(.MEM_DEPTH(MEM_DEPTH)) u_mem (
    .clk, .rst_n,
    .we    (wr_commit),
    .waddr (ctr),
    .wdata (shreg),
    .raddr (ctr),
    .rdata (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      abyte     <= '0;
      addr_acc  <= '0;
      sda_oe    <= 1'b0;
    end else if (ser_en_n) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt != CW'(BYTE_BITS)) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == ST_DEV) begin
              if (dev_hit) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                after_ack <= shreg[0] ? ST_RDATA : ST_ADDR;
                abyte     <= '0;
              end else begin
                state <= ST_SKIP;
              end
            end else if (state == ST_ADDR) begin
              addr_acc  <= AW'({addr_acc, shreg});
              abyte     <= abyte + 1'b1;
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              after_ack <= addr_last ? ST_WDATA : ST_ADDR;
            end else begin
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              after_ack <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            state  <= after_ack;
            if (after_ack == ST_RDATA) begin
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (rd_done) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_RACK;
          end else if (scl_fall) begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
          end
        end
        ST_RACK: begin
          if (nack_seen) begin
            state <= ST_SKIP;
          end else if (scl_rise) begin
            bitcnt <= CW'(1);
          end else if (scl_fall && bitcnt == CW'(1)) begin
            bitcnt <= '0;
            shreg  <= rd_byte;
            sda_oe <= ~rd_byte[7];
            state  <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: the drive never changes across a high clock phase
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !ser_en_n && $past(!ser_en_n)) |-> $stable(sda_oe));

  // R2: a matching identity is acknowledged
  p_ack_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_hit |=> sda_oe);

  // R3: a foreign identity is left unacknowledged and the bus is skipped
  p_no_ack_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss |=> (!sda_oe && state == ST_SKIP));

  // R3: while skipping, the data line is never pulled
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  // R8: a not-acknowledge leaves SDA released
  p_release_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> !sda_oe);
endmodule

// File: tb/twm_target_tb.sv
module twm_target_tb;
  localparam int Q = 8;
  localparam logic [6:0] ID = 7'h50;

  // Stimulus table: {is_read, 24-bit address, data or expected data}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 24'h000010, 8'hA5},
    {1'b0, 24'h000011, 8'h3C},
    {1'b0, 24'hFF0020, 8'h77},
    {1'b0, 24'h0000FF, 8'h81},
    {1'b0, 24'h000000, 8'h5A},
    {1'b1, 24'h000010, 8'hA5},
    {1'b1, 24'h000020, 8'h77},
    {1'b1, 24'h0000FF, 8'h81}
  };

  logic clk = 1'b0, rst_n = 1'b0, ser_en_n = 1'b1, scl = 1'b1, sda_c = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_c & ~sda_oe;

  always #2 clk = ~clk;

  twm_target #(.DEV_ID(ID)) u_dut (
    .clk, .rst_n, .ser_en_n, .scl_i(scl), .sda_i(sda_line), .sda_oe
  );

  int n_cmp = 0, n_bad = 0, r10_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_c = 1'b1; q(); scl = 1'b1; q(); sda_c = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bstop();
    sda_c = 1'b0; q(); scl = 1'b1; q(); sda_c = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_c = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    sda_c = 1'b1; q(); scl = 1'b1; q(); ack = !sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    sda_c = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; q(); d[i] = sda_line; q(); scl = 1'b0; q();
    end
    sda_c = !give_ack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); sda_c = 1'b1;
  endtask

  task automatic hdr(input logic [23:0] a, input string tag);
    logic ack;
    bstart();
    send_byte({ID, 1'b0}, ack); check({tag, " R2 dev ack"}, ack, 1);
    send_byte(a[23:16], ack);   check({tag, " R4 msb ack"}, ack, 1);
    send_byte(a[15:8], ack);    check({tag, " R4 mid ack"}, ack, 1);
    send_byte(a[7:0], ack);     check({tag, " R4 lsb ack"}, ack, 1);
  endtask

  task automatic rcur(input logic [7:0] exp, input string tag);
    logic ack;
    logic [7:0] d;
    bstart();
    send_byte({ID, 1'b1}, ack); check({tag, " R2 read dev ack"}, ack, 1);
    recv_byte(1'b0, d);          check(tag, d, exp);
    bstop();
  endtask

  task automatic rrand(input logic [23:0] a, input logic [7:0] exp, input string tag);
    hdr(a, tag);
    bstop();
    rcur(exp, tag);
  endtask

  // R10 monitor: sda_oe must not move between two high SCL samples
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always begin
    @(posedge clk); #1;
    if (rst_n && !ser_en_n && scl && scl_prev && sda_oe != oe_prev) r10_bad++;
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    check("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    q();
    ser_en_n = 1'b0;
    q();
    check("R1 sda_oe after reset", sda_oe, 0);
    rcur(8'h00, "R1 first read of byte 0");

    // table walk: writes then random reads (R4 upper bits in entry 2)
    foreach (VEC[i]) begin
      if (VEC[i][32]) begin
        rrand(VEC[i][31:8], VEC[i][7:0], "R7 random read");
      end else begin
        hdr(VEC[i][31:8], "R5 write");
        send_byte(VEC[i][7:0], ack); check("R5 data ack", ack, 1);
        bstop();
      end
    end

    // counter wrapped from 0xFF to 0 after last table read
    rcur(8'h5A, "R6 current read after wrap");

    // two bytes across a page boundary: 0x0F then 0x10
    hdr(24'h00000F, "R5 page");
    send_byte(8'hD1, ack); check("R5 page data0 ack", ack, 1);
    send_byte(8'hD2, ack); check("R5 page data1 ack", ack, 1);
    bstop();
    rcur(8'h3C, "R9 counter kept at 0x11");
    rrand(24'h000010, 8'hD2, "R5 rollover byte at 0x10");

    // sequential read from 0x0F
    hdr(24'h00000F, "R8 seq");
    bstop();
    bstart();
    send_byte({ID, 1'b1}, ack); check("R8 seq dev ack", ack, 1);
    recv_byte(1'b1, d); check("R8 seq byte0", d, 8'hD1);
    recv_byte(1'b1, d); check("R8 seq byte1", d, 8'hD2);
    recv_byte(1'b0, d); check("R8 seq byte2", d, 8'h3C);
    check("R8 released after nack", sda_oe, 0);
    bstop();
    check("R8 released after stop", sda_oe, 0);

    // foreign identity: nothing acknowledged, nothing stored
    bstart();
    send_byte({7'h51, 1'b0}, ack); check("R3 foreign dev nack", ack, 0);
    send_byte(8'h00, ack); check("R3 byte nack", ack, 0);
    send_byte(8'h00, ack); check("R3 byte nack", ack, 0);
    send_byte(8'h10, ack); check("R3 byte nack", ack, 0);
    send_byte(8'hEE, ack); check("R3 data nack", ack, 0);
    bstop();
    rcur(8'h00, "R9 counter kept past foreign txn (0x12)");
    rrand(24'h000010, 8'hD2, "R3 byte 0x10 unchanged");

    // enable high clears the counter (now 0x11)
    ser_en_n = 1'b1;
    q();
    check("R9 released while disabled", sda_oe, 0);
    ser_en_n = 1'b0;
    q();
    rcur(8'h5A, "R9 counter cleared to 0");

    check("R10 sda_oe changes only with SCL low", r10_bad, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule